// File: doc/BRIEF.md
# Two-wire serial memory slave protocol engine

This block is the bus-facing controller of a 256-byte serial memory. It watches the two-wire clock and data lines, which have already been synchronised to a fast system clock. It recognises the START and STOP conditions and checks the slave address byte against a fixed memory type code and three strap pins. It then shifts bytes in and out, bit by bit. The block drives the data line only through an open-drain pull-down enable. It acknowledges received bytes, writes data into an external memory port and reads data back for transmission.

A persistent address pointer survives from one transaction to the next. Writes advance the pointer inside a 16-byte page. Reads advance it through the whole array and wrap from the top address to zero, which provides current reads and sequential reads. An external write-cycle timer reports a busy flag, and external protection logic grants acknowledge permission for each received byte. The block reports which kind of byte is being received so that the protection logic can decide.

Top module: `i2c_mem_slave`

## Requirements
- R1: A START (data falling while the clock is high) restarts address reception from any state. A STOP (data rising while the clock is high) returns the block to idle with the data line released, including a STOP in the middle of a partly received address byte.
- R2: The address byte is type code 1010 in bits 7..4, the strap value in bits 3..1 and the read/write flag in bit 0 (1 = read). On any mismatch the slave gives no ACK and stays silent until the next START or STOP.
- R3: The pull-down enable is low at reset and whenever no ACK or read data bit is being driven. It changes only while the clock line is low.
- R4: A matched address byte, a word address byte and each write data byte are acknowledged (data held low during the ninth clock) only if ack_allow_i is high when the byte completes. Otherwise the slave gives no ACK, performs no write and ignores the bus until the next START or STOP.
- R5: A write data byte is stored at the pointer, and then only the low 4 pointer bits increment. A page write longer than 16 bytes therefore wraps inside its 16-byte page and overwrites earlier data.
- R6: Random read: a write address byte plus a word address, then a repeated START with a read address byte, returns the byte at that word address.
- R7: Each transmitted byte advances the pointer by one over all 256 addresses, from FFh to 00h. A current read returns the byte after the last one accessed.
- R8: A master NACK after a read byte ends transmission, and further clocks see the data line released until a START or STOP.
- R9: While busy_i is high, an address byte gets no ACK and nothing is written.
- R10: After reset, and after a START or STOP that interrupts a read before the master NACK, the pointer is undefined. A current read address byte is then not acknowledged until a word address has been written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronised serial clock line |
| sda_i | input | 1 | Synchronised serial data line (resolved bus level) |
| sda_oe | output | 1 | Open-drain enable, 1 pulls the data line low |
| strap_i | input | 3 | Device address strap pins |
| busy_i | input | 1 | External write cycle in progress |
| ack_allow_i | input | 1 | Permission to acknowledge the byte now completing |
| ack_phase_o | output | 2 | Byte being received: 0 address, 1 word address, 2 write data, 3 none |
| mem_addr_o | output | 8 | Memory address (current pointer) |
| mem_wr_o | output | 1 | One-cycle write strobe |
| mem_wdata_o | output | 8 | Write data |
| mem_rd_o | output | 1 | One-cycle strobe when a read byte is fetched |
| mem_rdata_i | input | 8 | Memory read data for mem_addr_o, same cycle |

## Verification
A wrong pointer shows up at the very next read byte, as a data value that differs from the reference array. A page-wrap error shows up when the page is read back after the write transaction. A state machine stuck in the wrong phase shows up within one byte time, as an ACK bit with the wrong level or a read byte that is not all ones after a NACK or an address mismatch. A drive enable that moves while the clock is high is caught in the same system clock cycle.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_MACK,
    ST_IGNORE
  } state_e;

  typedef enum logic [1:0] {
    PH_DEV   = 2'd0,
    PH_WADDR = 2'd1,
    PH_WDATA = 2'd2,
    PH_NONE  = 2'd3
  } phase_e;

  localparam int          BYTE_W      = 8;
  localparam logic [3:0]  MEM_TYPE_ID = 4'b1010;
endpackage

// File: rtl/i2cm_bus_events.sv
module i2cm_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/i2cm_addr_ptr.sv
module i2cm_addr_ptr #(
  parameter int ADDR_W = 8,
  parameter int PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_val_i,
  input  logic              step_seq_i,
  input  logic              step_page_i,
  input  logic              inval_i,
  output logic [ADDR_W-1:0] ptr_o,
  output logic              valid_o
);
  logic [ADDR_W-1:0] ptr_q, ptr_n;
  logic              val_q, val_n;
  logic              en;

  always_comb begin
    ptr_n = ptr_q;
    val_n = val_q;
    if (load_i) begin
      ptr_n = load_val_i;
      val_n = 1'b1;
    end else if (step_seq_i) begin
      ptr_n = ptr_q + ADDR_W'(1);
    end else if (step_page_i) begin
      ptr_n = {ptr_q[ADDR_W-1:PAGE_W], ptr_q[PAGE_W-1:0] + PAGE_W'(1)};
    end
    if (inval_i) val_n = 1'b0;
  end

  assign en = load_i | step_seq_i | step_page_i | inval_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      val_q <= 1'b0;
    end else if (en) begin
      ptr_q <= ptr_n;
      val_q <= val_n;
    end
  end

  assign ptr_o   = ptr_q;
  assign valid_o = val_q;

  // R7: sequential stepping wraps from the top address to zero
  a_r7_seq_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (step_seq_i && !load_i && ptr_o == '1) |=> (ptr_o == '0));

  // R5: page stepping never changes the page bits
  a_r5_page_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (step_page_i && !load_i && !step_seq_i) |=>
      (ptr_o[ADDR_W-1:PAGE_W] == $past(ptr_o[ADDR_W-1:PAGE_W])));
endmodule

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave
  import i2cm_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int PAGE_W  = 4,
  parameter int STRAP_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               busy_i,
  input  logic               ack_allow_i,
  output logic [1:0]         ack_phase_o,
  output logic [ADDR_W-1:0]  mem_addr_o,
  output logic               mem_wr_o,
  output logic [BYTE_W-1:0]  mem_wdata_o,
  output logic               mem_rd_o,
  input  logic [BYTE_W-1:0]  mem_rdata_i
);
  localparam int CNT_W  = $clog2(BYTE_W + 1);
  localparam int TYPE_W = BYTE_W - 1 - STRAP_W;

  logic scl_rise, scl_fall, start_ev, stop_ev;

  i2cm_bus_events u_ev (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (start_ev),
    .stop_o    (stop_ev)
  );

  state_e             st_q, st_n;
  phase_e             ph_q, ph_n;
  logic [BYTE_W-1:0]  sh_q, sh_n;
  logic [CNT_W-1:0]   cnt_q, cnt_n;
  logic               oe_q, oe_n;
  logic               tx_q, tx_n;

  logic               p_load, p_seq, p_page, p_inval;
  logic [ADDR_W-1:0]  ptr;
  logic               ptr_valid;
  logic               dev_decide, accept, wr_s, rd_s;
  logic               type_ok, strap_ok;

  i2cm_addr_ptr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ptr (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (p_load),
    .load_val_i (sh_q[ADDR_W-1:0]),
    .step_seq_i (p_seq),
    .step_page_i(p_page),
    .inval_i    (p_inval),
    .ptr_o      (ptr),
    .valid_o    (ptr_valid)
  );

  assign type_ok  = (sh_q[BYTE_W-1 -: TYPE_W] == MEM_TYPE_ID[TYPE_W-1:0]);
  assign strap_ok = (sh_q[STRAP_W:1] == strap_i);

  always_comb begin
    st_n    = st_q;
    ph_n    = ph_q;
    sh_n    = sh_q;
    cnt_n   = cnt_q;
    oe_n    = oe_q;
    tx_n    = tx_q;
    p_load  = 1'b0;
    p_seq   = 1'b0;
    p_page  = 1'b0;
    p_inval = 1'b0;
    wr_s    = 1'b0;
    rd_s    = 1'b0;
    accept  = 1'b0;
    dev_decide = 1'b0;

    if (start_ev || stop_ev) begin
      if (st_q == ST_TX || st_q == ST_MACK || (st_q == ST_ACK && tx_q))
        p_inval = 1'b1;
      oe_n  = 1'b0;
      cnt_n = '0;
      ph_n  = PH_DEV;
      st_n  = start_ev ? ST_RX : ST_IDLE;
    end else begin
      case (st_q)
        ST_RX: begin
          if (scl_rise) begin
            sh_n  = {sh_q[BYTE_W-2:0], sda_i};
            cnt_n = cnt_q + CNT_W'(1);
          end else if (scl_fall && cnt_q == CNT_W'(BYTE_W)) begin
            case (ph_q)
              PH_DEV: begin
                dev_decide = 1'b1;
                accept = type_ok && strap_ok && !busy_i && ack_allow_i &&
                         (!sh_q[0] || ptr_valid);
                tx_n   = sh_q[0];
              end
              PH_WADDR: begin
                accept = ack_allow_i;
                p_load = accept;
              end
              default: begin
                accept = ack_allow_i;
                wr_s   = accept;
                p_page = accept;
              end
            endcase
            oe_n = accept;
            st_n = accept ? ST_ACK : ST_IGNORE;
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            cnt_n = '0;
            if (tx_q) begin
              rd_s  = 1'b1;
              p_seq = 1'b1;
              sh_n  = mem_rdata_i;
              oe_n  = ~mem_rdata_i[BYTE_W-1];
              st_n  = ST_TX;
            end else begin
              oe_n = 1'b0;
              ph_n = (ph_q == PH_DEV) ? PH_WADDR : PH_WDATA;
              st_n = ST_RX;
            end
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            cnt_n = cnt_q + CNT_W'(1);
          end else if (scl_fall) begin
            if (cnt_q == CNT_W'(BYTE_W)) begin
              oe_n = 1'b0;
              st_n = ST_MACK;
            end else begin
              sh_n = {sh_q[BYTE_W-2:0], 1'b0};
              oe_n = ~sh_q[BYTE_W-2];
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            if (sda_i) st_n = ST_IGNORE;
          end else if (scl_fall) begin
            cnt_n = '0;
            rd_s  = 1'b1;
            p_seq = 1'b1;
            sh_n  = mem_rdata_i;
            oe_n  = ~mem_rdata_i[BYTE_W-1];
            st_n  = ST_TX;
          end
        end
        default: begin
          oe_n = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      ph_q  <= PH_DEV;
      sh_q  <= '0;
      cnt_q <= '0;
      oe_q  <= 1'b0;
      tx_q  <= 1'b0;
    end else begin
      st_q  <= st_n;
      ph_q  <= ph_n;
      sh_q  <= sh_n;
      cnt_q <= cnt_n;
      oe_q  <= oe_n;
      tx_q  <= tx_n;
    end
  end

  assign sda_oe      = oe_q;
  assign ack_phase_o = (st_q == ST_RX) ? ph_q : PH_NONE;
  assign mem_addr_o  = ptr;
  assign mem_wr_o    = wr_s;
  assign mem_wdata_o = sh_q;
  assign mem_rd_o    = rd_s;

  // R3: the drive enable only moves while the clock line is low
  a_r3_oe_moves_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !$past(scl_i));

  // R9: busy at the address decision means no acknowledge
  a_r9_busy_nack: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_decide && busy_i) |=> !sda_oe);

  // R4: every accepted write is followed by the acknowledge drive
  a_r4_write_acked: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_o |=> sda_oe);

  // R8: nothing is driven while the bus is being ignored
  a_r8_ignore_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IGNORE || st_q == ST_IDLE) |-> !sda_oe);

  // R10: a current read with an undefined pointer is refused
  a_r10_undef_read: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_decide && sh_q[0] && !ptr_valid) |=> !sda_oe);
endmodule

// File: tb/tb_i2c_mem_slave.sv
module tb_i2c_mem_slave;
  localparam int H = 8;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] DEV_W = {4'b1010, STRAP, 1'b0};
  localparam logic [7:0] DEV_R = {4'b1010, STRAP, 1'b1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic busy = 1'b0;
  logic allow = 1'b1;
  logic sda_line;
  logic sda_oe, mem_wr, mem_rd;
  logic [1:0] ack_phase;
  logic [7:0] mem_addr, mem_wdata, mem_rdata;

  logic [7:0] mem  [256];
  logic [7:0] refm [256];
  int ref_ptr;
  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  assign sda_line  = m_sda & ~sda_oe;
  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) if (mem_wr) mem[mem_addr] <= mem_wdata;

  i2c_mem_slave dut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .strap_i(STRAP), .busy_i(busy), .ack_allow_i(allow), .ack_phase_o(ack_phase),
    .mem_addr_o(mem_addr), .mem_wr_o(mem_wr), .mem_wdata_o(mem_wdata),
    .mem_rd_o(mem_rd), .mem_rdata_i(mem_rdata)
  );

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // per-clock reference: the drive enable may not move while the clock is high (R3)
  logic oe_prev = 1'b0, scl_prev = 1'b1;
  always @(negedge clk) begin
    if (rst_n) begin
      n_cmp++;
      if (sda_oe != oe_prev && scl_prev) begin
        n_bad++;
        $display("FAIL R3 oe moved with clock high act %0b exp %0b", sda_oe, oe_prev);
      end
    end
    oe_prev  = sda_oe;
    scl_prev = m_scl;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog (R1..R10 unfinished) act %0d exp %0d", cyc, 0);
      summary();
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act %0h exp %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; tick(H);
    m_scl = 1'b1; tick(H);
    m_sda = 1'b0; tick(H);
    m_scl = 1'b0;
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(H);
    m_scl = 1'b1; tick(H);
    m_sda = 1'b1; tick(H);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      m_sda = b[i]; tick(H);
      m_scl = 1'b1; tick(H);
      m_scl = 1'b0;
    end
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    m_sda = 1'b1; tick(H);
    m_scl = 1'b1; tick(H / 2);
    ack = sda_line; tick(H / 2);
    m_scl = 1'b0;
  endtask

  task automatic rbyte(input logic mack, output logic [7:0] b);
    m_sda = 1'b1;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      tick(H);
      m_scl = 1'b1; tick(H / 2);
      b = {b[6:0], sda_line}; tick(H / 2);
      m_scl = 1'b0;
    end
    m_sda = mack ? 1'b0 : 1'b1; tick(H);
    m_scl = 1'b1; tick(H);
    m_scl = 1'b0;
    m_sda = 1'b1;
  endtask

  task automatic do_write(input int a, input int n, input int v0, input string req);
    logic ack;
    bus_start();
    wbyte(DEV_W, ack); chk({req, " address ack"}, ack, 0);
    wbyte(8'(a), ack); chk({req, " word ack"}, ack, 0);
    for (int i = 0; i < n; i++) begin
      logic [7:0] v;
      v = 8'(v0 + 3 * i);
      wbyte(v, ack); chk({req, " data ack"}, ack, 0);
      refm[{a[7:4], 4'(a + i)}] = v;
    end
    bus_stop();
    ref_ptr = {a[7:4], 4'(a + n)};
  endtask

  task automatic do_rand_read(input int a, input int n, input string req);
    logic ack;
    logic [7:0] b;
    bus_start();
    wbyte(DEV_W, ack); chk({req, " address ack"}, ack, 0);
    wbyte(8'(a), ack); chk({req, " word ack"}, ack, 0);
    bus_start();
    wbyte(DEV_R, ack); chk({req, " read address ack"}, ack, 0);
    for (int i = 0; i < n; i++) begin
      rbyte(i < n - 1, b);
      chk({req, " read data"}, b, refm[(a + i) & 255]);
    end
    bus_stop();
    ref_ptr = (a + n) & 255;
  endtask

  task automatic do_cur_read(input int n, input string req);
    logic ack;
    logic [7:0] b;
    bus_start();
    wbyte(DEV_R, ack); chk({req, " current read ack"}, ack, 0);
    for (int i = 0; i < n; i++) begin
      rbyte(i < n - 1, b);
      chk({req, " current read data"}, b, refm[(ref_ptr + i) & 255]);
    end
    bus_stop();
    ref_ptr = (ref_ptr + n) & 255;
  endtask

  initial begin
    logic ack;
    logic [7:0] b;
    for (int i = 0; i < 256; i++) begin
      mem[i]  = 8'(i * 7 + 3);
      refm[i] = 8'(i * 7 + 3);
    end
    mem[8'h90] = 8'hFF; refm[8'h90] = 8'hFF;
    mem[8'h91] = 8'hFF; refm[8'h91] = 8'hFF;
    ref_ptr = 0;
    tick(5);
    chk("R3 enable at reset", sda_oe, 0);
    rst_n = 1'b1;
    tick(4);
    chk("R3 enable after reset", sda_oe, 0);

    // R10: pointer undefined after reset
    bus_start();
    wbyte(DEV_R, ack); chk("R10 current read after reset", ack, 1);
    bus_stop();

    // R4 R5 R6: byte write then random read
    do_write(8'h10, 1, 8'h5A, "R4");
    do_rand_read(8'h10, 1, "R6");

    // R5: page write of 20 bytes from 2Ch wraps inside page 20h..2Fh
    do_write(8'h2C, 20, 8'h80, "R5");
    do_rand_read(8'h20, 16, "R5");

    // R7: current read continues after last access, sequential wrap
    do_cur_read(2, "R7");
    do_rand_read(8'hFE, 4, "R7 wrap");

    // R8: master NACK ends the read
    bus_start();
    wbyte(DEV_W, ack); chk("R8 address ack", ack, 0);
    wbyte(8'h40, ack); chk("R8 word ack", ack, 0);
    bus_start();
    wbyte(DEV_R, ack); chk("R8 read address ack", ack, 0);
    rbyte(1'b0, b); chk("R8 data", b, refm[8'h40]);
    rbyte(1'b0, b); chk("R8 released after NACK", b, 8'hFF);
    bus_stop();
    ref_ptr = 8'h41;
    do_cur_read(1, "R8 R7");

    // R2: strap and type mismatch
    bus_start();
    wbyte({4'b1010, 3'b011, 1'b0}, ack); chk("R2 strap mismatch", ack, 1);
    wbyte(8'h00, ack); chk("R2 ignored byte", ack, 1);
    bus_stop();
    bus_start();
    wbyte({4'b0110, STRAP, 1'b0}, ack); chk("R2 type mismatch", ack, 1);
    bus_stop();

    // R9: busy blocks acknowledge and writes
    busy = 1'b1;
    bus_start();
    wbyte(DEV_W, ack); chk("R9 busy address", ack, 1);
    wbyte(8'h51, ack); chk("R9 busy word", ack, 1);
    wbyte(8'h99, ack); chk("R9 busy data", ack, 1);
    bus_stop();
    busy = 1'b0;
    do_write(8'h50, 1, 8'h33, "R9 after busy");
    do_rand_read(8'h50, 2, "R9 readback");

    // R4: permission withheld for a data byte
    bus_start();
    wbyte(DEV_W, ack); chk("R4 address ack", ack, 0);
    wbyte(8'h60, ack); chk("R4 word ack", ack, 0);
    allow = 1'b0;
    wbyte(8'h77, ack); chk("R4 refused data", ack, 1);
    allow = 1'b1;
    wbyte(8'h78, ack); chk("R4 ignored after refusal", ack, 1);
    bus_stop();
    do_rand_read(8'h60, 1, "R4 unchanged");

    // R1: STOP inside a partial address byte, then normal operation
    bus_start();
    send_bits(DEV_W, 4);
    bus_stop();
    chk("R1 idle after abort", sda_oe, 0);
    do_rand_read(8'h10, 1, "R1 after abort");

    // R1: START in the middle of a data byte restarts address reception
    bus_start();
    wbyte(DEV_W, ack); chk("R1 address ack", ack, 0);
    wbyte(8'h70, ack); chk("R1 word ack", ack, 0);
    send_bits(8'h12, 3);
    bus_start();
    wbyte(DEV_R, ack); chk("R1 restart read ack", ack, 0);
    rbyte(1'b0, b); chk("R1 restart read data", b, refm[8'h70]);
    bus_stop();

    // R10: START during read transmission makes the pointer undefined
    bus_start();
    wbyte(DEV_W, ack); chk("R10 address ack", ack, 0);
    wbyte(8'h90, ack); chk("R10 word ack", ack, 0);
    bus_start();
    wbyte(DEV_R, ack); chk("R10 read ack", ack, 0);
    rbyte(1'b1, b); chk("R10 first byte", b, 8'hFF);
    bus_start();
    bus_stop();
    bus_start();
    wbyte(DEV_R, ack); chk("R10 current read refused", ack, 1);
    bus_stop();
    do_rand_read(8'h91, 1, "R10 random read recovers");

    // R5: full memory image matches the reference array
    begin
      int diffs;
      diffs = 0;
      for (int i = 0; i < 256; i++) if (mem[i] !== refm[i]) diffs++;
      chk("R5 memory image differences", diffs, 0);
    end

    done = 1;
    tick(4);
    summary();
  end
endmodule